// File: doc/BRIEF.md
# Subscan Line Scaler

This block scales a page in the line-to-line direction without interpolating. It decides, for each incoming line, how many times an external line buffer must replay that line. The answer is zero (the line is dropped), one, or more than one (the line is repeated). The block never touches pixel data. It only paces the replay by strobing one output request per copy and waiting for each request to be acknowledged. It behaves the same whether the surrounding pipeline is encoding, decoding, converting between codes or just moving raw lines.

There are two ways to set the scale. In fractional mode a 17-bit factor is read with 65536 as unity, so the range runs from one part in 65536 up to just under 2.0. This factor is added into a 16-bit phase register once per line, and the integer carry of that sum (0, 1 or 2) is the copy count. In integer mode every line is emitted a programmed number of times, up to 65535. A start-of-page pulse clears the phase, so each page follows the same drop/repeat pattern.

The control is a three-state machine. **ST_IDLE** accepts a line and goes to ST_EMIT when the copy count is nonzero, or to ST_DONE when it is zero. It stays put on page start. **ST_EMIT** takes ST_EMIT→ST_EMIT on an acknowledge that is not the last, ST_EMIT→ST_DONE on the acknowledge of the last copy, and ST_EMIT→ST_IDLE on page start. **ST_DONE** always returns to ST_IDLE after one cycle.

Top module: `subscan_scaler`

## Requirements
- R1: After reset `in_ready` is 1, `emit`, `emit_last` and `line_done` are 0, and the phase register holds zero.
- R2: In fractional mode (`mode_int`=0) an accepted line is emitted floor((phase + factor) / 65536) times, where `factor` is unsigned with 65536 meaning 1.0. The new phase is (phase + factor) mod 65536.
- R3: A `factor` of 0 in fractional mode is used as 1.
- R4: In integer mode (`mode_int`=1) an accepted line is emitted `rep_count` times, with 0 used as 1. The phase register is left unchanged.
- R5: A line is accepted only on a cycle with `in_valid`=1, `in_ready`=1 and `page_start`=0. `in_ready` is 1 only in ST_IDLE.
- R6: `emit` stays high until a cycle with `emit_ack`=1, and each such cycle completes exactly one copy. `emit_last` is 1 exactly while the final copy of the line is being requested.
- R7: `line_done` pulses for one cycle after the last copy is acknowledged, or one cycle after acceptance for a zero-copy line. `in_ready` is 1 on the following cycle.
- R8: `page_start` clears the phase to zero and returns the machine to ST_IDLE. It takes priority over `in_valid`.
- R9: `mode_int`, `factor` and `rep_count` are sampled only at acceptance. Changing them while the copies of a line are going out has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Start of page: clears phase, aborts to idle |
| in_valid | input | 1 | A new input line is available |
| in_ready | output | 1 | Block can accept a line (idle) |
| mode_int | input | 1 | 1 = integer replication, 0 = fractional |
| factor | input | 17 | Fractional step, 65536 = unity |
| rep_count | input | 16 | Copies per line in integer mode |
| emit | output | 1 | Request to replay the current line once |
| emit_ack | input | 1 | Replay of one copy accepted |
| emit_last | output | 1 | Current request is the line's final copy |
| line_done | output | 1 | One-cycle pulse: all copies of the line are out |

## Verification
The bench targets zero-copy lines, which must raise `line_done` without any `emit`. A design that always emits at least once would show up as a miscompare on a dropped line. Factors of 50%, 150% and just under 200% show whether the fraction is carried correctly from line to line: a design that loses the carry, or clips a double carry to one, gives the wrong count on alternating lines. A zero factor is tested after the phase has been brought to 0xFFFF, and a page start is tested after the phase has been left at one half. In both cases a wrong design shifts the next count by one. Integer counts of 0, 1, 2, 5 and 1000 are run, and inputs are scrambled right after every acceptance, which catches a design that rereads its settings during emission or miscounts long runs.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } ssc_state_e;
endpackage

// File: rtl/ssc_phase_accum.sv
module ssc_phase_accum #(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step_en,
    input  logic [FRAC_W:0]   factor,
    output logic [1:0]        carry
);
    localparam int SUM_W = FRAC_W + 2;

    logic [FRAC_W-1:0] phase_q;
    logic [FRAC_W:0]   step_eff;
    logic [SUM_W-1:0]  sum;

    // A zero step would freeze the page at zero copies; use the least step instead.
    always_comb begin
        step_eff = (factor == '0) ? {{FRAC_W{1'b0}}, 1'b1} : factor;
        sum      = {2'b00, phase_q} + {1'b0, step_eff};
        carry    = sum[SUM_W-1:FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (step_en) begin
            phase_q <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/ssc_copy_counter.sv
module ssc_copy_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_last
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign is_last = (left_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
    import ssc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic page_start,
    input  logic in_valid,
    input  logic zero_copies,
    input  logic emit_ack,
    input  logic is_last,
    output logic accept,
    output logic in_ready,
    output logic emit,
    output logic emit_last,
    output logic line_done
);
    ssc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!page_start && in_valid)
                    state_d = zero_copies ? ST_DONE : ST_EMIT;
            end
            ST_EMIT: begin
                if (page_start)
                    state_d = ST_IDLE;
                else if (emit_ack && is_last)
                    state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        emit      = (state_q == ST_EMIT);
        emit_last = (state_q == ST_EMIT) && is_last;
        line_done = (state_q == ST_DONE);
        accept    = (state_q == ST_IDLE) && in_valid && !page_start;
    end
endmodule

// File: rtl/subscan_scaler.sv
module subscan_scaler #(
    parameter int FRAC_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              mode_int,
    input  logic [FRAC_W:0]   factor,
    input  logic [CNT_W-1:0]  rep_count,
    output logic              emit,
    input  logic              emit_ack,
    output logic              emit_last,
    output logic              line_done
);
    logic             accept;
    logic [1:0]       carry;
    logic             is_last;
    logic [CNT_W-1:0] rep_eff;
    logic [CNT_W-1:0] copies;

    always_comb begin
        rep_eff = (rep_count == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : rep_count;
        copies  = mode_int ? rep_eff : {{(CNT_W-2){1'b0}}, carry};
    end

    ssc_phase_accum #(.FRAC_W(FRAC_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (page_start),
        .step_en (accept && !mode_int),
        .factor  (factor),
        .carry   (carry)
    );

    ssc_copy_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (copies),
        .dec      (emit && emit_ack),
        .is_last  (is_last)
    );

    ssc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .page_start  (page_start),
        .in_valid    (in_valid),
        .zero_copies (copies == '0),
        .emit_ack    (emit_ack),
        .is_last     (is_last),
        .accept      (accept),
        .in_ready    (in_ready),
        .emit        (emit),
        .emit_last   (emit_last),
        .line_done   (line_done)
    );
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker (
    input logic clk,
    input logic rst_n,
    input logic page_start,
    input logic in_valid,
    input logic in_ready,
    input logic emit,
    input logic emit_ack,
    input logic emit_last,
    input logic line_done
);
    // R5
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !page_start) |=> !in_ready);

    // R6
    emit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !emit_ack && !page_start) |=> emit);

    // R6
    last_in_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_last |-> emit);

    // R7
    last_ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_last && emit_ack && !page_start) |=> line_done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> (!line_done && in_ready));

    // R8
    page_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (in_ready && !emit));
endmodule

bind subscan_scaler ssc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_start (page_start),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .emit       (emit),
    .emit_ack   (emit_ack),
    .emit_last  (emit_last),
    .line_done  (line_done)
);

// File: tb/sim_subscan_scaler.sv
`timescale 1ns/1ps
module sim_subscan_scaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        mode_int = 1'b0;
    logic [16:0] factor = '0;
    logic [15:0] rep_count = '0;
    logic        emit;
    logic        emit_ack = 1'b0;
    logic        emit_last;
    logic        line_done;

    always #5 clk = ~clk;

    subscan_scaler u0 (
        .clk(clk), .rst_n(rst_n), .page_start(page_start),
        .in_valid(in_valid), .in_ready(in_ready), .mode_int(mode_int),
        .factor(factor), .rep_count(rep_count), .emit(emit),
        .emit_ack(emit_ack), .emit_last(emit_last), .line_done(line_done)
    );

    typedef struct { int n; string req; } exp_t;
    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   phase_m = 0;
    int   cyc = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || !in_ready) @(negedge clk);
    endtask

    task automatic new_page();
        wait_idle();
        page_start = 1'b1;
        @(negedge clk);
        page_start = 1'b0;
        phase_m = 0;
    endtask

    // Driver: model the count from the requirements, push it, then offer the line.
    task automatic send(input bit m, input int f, input int r, input string req);
        exp_t e;
        int s;
        if (m) begin
            e.n = (r == 0) ? 1 : r;                    // R4
        end else begin
            s = phase_m + ((f == 0) ? 1 : f);          // R2, R3
            e.n = s >> 16;
            phase_m = s & 16'hFFFF;
        end
        e.req = req;
        q.push_back(e);
        mode_int  = m;
        factor    = f[16:0];
        rep_count = r[15:0];
        in_valid  = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid  = 1'b0;
        // R9: scramble the settings while the copies go out
        mode_int  = ~m;
        factor    = 17'h1ABCD;
        rep_count = 16'd777;
    endtask

    // Monitor and acknowledge responder, one process so the ack seen is the ack counted.
    int  got = 0;
    bit  ready_due = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            if (ready_due) begin
                check(in_ready == 1'b1, "R7", int'(in_ready), 1);
                ready_due = 0;
            end
            emit_ack = emit && (cyc % 3 != 1);
            if (emit && q.size() != 0) begin
                check(emit_last == ((got + 1) == q[0].n), "R6",
                      int'(emit_last), int'((got + 1) == q[0].n));
            end
            if (emit && emit_ack) got++;
            if (line_done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R5", got, -1);
                end else begin
                    check(got == q[0].n, q[0].req, got, q[0].n);
                    void'(q.pop_front());
                end
                got = 0;
                ready_due = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finished = 1;
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);
        check(emit == 1'b0 && emit_last == 1'b0, "R1", int'(emit), 0);
        check(line_done == 1'b0, "R1", int'(line_done), 0);
        // R1: phase starts at zero, so a 50% line yields nothing
        send(0, 32'h8000, 0, "R1");
        send(0, 32'h8000, 0, "R2");
        send(0, 32'h8000, 0, "R2");
        send(0, 32'h8000, 0, "R2");
        new_page();
        for (int i = 0; i < 4; i++) send(0, 32'h18000, 0, "R2");
        for (int i = 0; i < 3; i++) send(0, 32'h1FFFF, 0, "R2");
        new_page();
        send(0, 32'hFFFF, 0, "R3");
        send(0, 0, 0, "R3");
        new_page();
        send(0, 32'h8000, 0, "R8");
        new_page();
        send(0, 32'h8000, 0, "R8");
        send(1, 0, 2, "R4");
        send(1, 0, 5, "R9");
        send(1, 0, 0, "R4");
        send(1, 0, 1, "R4");
        send(1, 0, 1000, "R4");
        send(0, 32'h8000, 0, "R4");
        send(0, 32'h4000, 0, "R5");
        wait_idle();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R5", q.size(), 0);
        finished = 1;
        summary();
    end
endmodule